// File: doc/BRIEF.md
# Odd/Even Clock Ratio Chain

This block turns one of two incoming clocks into a slower output clock. A select input picks either the oscillator-derived clock or the reference clock as the source. The source is divided by a 5-bit integer ratio that may be odd or even. An optional power-of-two stage can then divide further by 1, 2, 4 or 8, so the total division is the ratio times the post factor. The output duty cycle stays at 50% for every setting, including odd ratios.

A synchronous run enable starts and stops the chain. While it is low, the counters are cleared and the output is held low. New ratio, post factor and source settings are captured only at the end of a complete output period, so a change never produces a shortened pulse. A build parameter removes the post stage and the reference option. In that variant the output is always the oscillator clock divided by the ratio alone.

Top module: `clk_ratio_chain`

## Requirements
- R1: With ratio P of 2 or more, the output period equals P times the post factor times the selected source period.
- R2: When the total division is even, the output is high for exactly half of its period.
- R3: With an odd P of 3 or more and post code 0, the output is high for P/2 source cycles, which is exactly 50%.
- R4: A ratio of 0 or 1 passes the source clock through with a period of one source cycle, whatever the post code is.
- R5: `src_sel` 0 selects `vco_clk` and 1 selects `ref_clk` as the source.
- R6: `post_sel` codes 0, 1, 2 and 3 give post factors of 1, 2, 4 and 8.
- R7: A setting changed partway through an output period takes effect only after that period completes: the current high and low times keep their old lengths.
- R8: From the second source rising edge after `run_en` is sampled low, the output stays low until the enable returns.
- R9: While `rst_n` is low, the output is low.
- R10: With `HAS_POST` = 0, `post_sel` and `src_sel` have no effect and the period is P cycles of `vco_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Oscillator-derived source clock |
| ref_clk | input | 1 | Reference source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Synchronous run enable, sampled on the source clock |
| p_ratio | input | P_W | Main divide ratio P, odd or even |
| post_sel | input | POST_W | Post factor code (factor 2^code) |
| src_sel | input | 1 | Source select: 0 oscillator, 1 reference |
| clk_out | output | 1 | Divided output clock |

## Verification
A new setting is captured at the first period boundary after it is applied, so it can take up to one full old period before it appears. The first new period then starts at the next rising output edge. The bench therefore skips two rising edges after any change, and measures high time and period on the third. After `run_en` falls, the output is sampled only from the third source cycle onward, which is past the two-edge latency in R8. For R7 the change is applied 1 ns after a rising output edge, and the edges that follow are timed against the old setting.

// File: rtl/rdiv_pkg.sv
`timescale 1ns/1ps
package rdiv_pkg;
  typedef enum logic {SRC_VCO = 1'b0, SRC_REF = 1'b1} src_e;

  // Smallest ratio that actually engages the counter.
  localparam int unsigned MIN_DIV = 2;
endpackage

// File: rtl/rdiv_rst_sync.sv
`timescale 1ns/1ps
module rdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rdiv_src_mux.sv
`timescale 1ns/1ps
module rdiv_src_mux
  import rdiv_pkg::*;
(
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic sel,
  output logic src_clk
);
  always_comb begin
    src_clk = (src_e'(sel) == SRC_REF) ? ref_clk : vco_clk;
  end
endmodule

// File: rtl/rdiv_core.sv
`timescale 1ns/1ps
module rdiv_core
  import rdiv_pkg::*;
#(
  parameter int unsigned P_W    = 5,
  parameter int unsigned POST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [P_W-1:0]    p_in,
  input  logic [POST_W-1:0] post_in,
  input  logic              sel_in,
  output logic              sel_q,
  output logic              clk_out
);
  localparam int unsigned PC_W = (1 << POST_W) - 1;
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};
  localparam logic [P_W-1:0]  P_MIN  = P_W'(MIN_DIV);

  logic [P_W-1:0]    cnt_q, cnt_d, p_q, p_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [POST_W-1:0] post_q, post_d;
  logic              sel_d, run_q, run_d, byp_q, byp_d, ph_q, ph_d, ph_n_q;
  logic [PC_W-1:0]   f_last_q, half_q;
  logic [P_W-1:0]    hi_q;
  logic              cnt_wrap, at_last, boundary, odd_q;

  // Derived from the held settings
  always_comb begin
    f_last_q = (PC_ONE << post_q) - PC_ONE;
    half_q   = (post_q == '0) ? PC_ONE : (PC_ONE << (post_q - 1'b1));
    hi_q     = (p_q >> 1) + {{(P_W-1){1'b0}}, p_q[0]};
    odd_q    = p_q[0] && (post_q == '0);
    cnt_wrap = (cnt_q == p_q - 1'b1);
    at_last  = byp_q || (cnt_wrap && (pc_q == f_last_q));
    boundary = !run_q || at_last;
  end

  // Next state
  always_comb begin
    cnt_d  = cnt_q;
    pc_d   = pc_q;
    p_d    = p_q;
    post_d = post_q;
    sel_d  = sel_q;
    byp_d  = byp_q;
    run_d  = run_q;
    ph_d   = ph_q;
    if (!en) begin
      run_d  = 1'b0;
      cnt_d  = '0;
      pc_d   = '0;
      ph_d   = 1'b0;
      p_d    = p_in;
      post_d = post_in;
      sel_d  = sel_in;
      byp_d  = (p_in < P_MIN);
    end else if (boundary) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      pc_d   = '0;
      ph_d   = 1'b1;
      p_d    = p_in;
      post_d = post_in;
      sel_d  = sel_in;
      byp_d  = (p_in < P_MIN);
    end else begin
      if (cnt_wrap) begin
        cnt_d = '0;
        pc_d  = pc_q + PC_ONE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      ph_d = (post_q != '0) ? (pc_d < half_q) : (cnt_d < hi_q);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pc_q   <= '0;
      p_q    <= '0;
      post_q <= '0;
      sel_q  <= 1'b0;
      byp_q  <= 1'b1;
      run_q  <= 1'b0;
      ph_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pc_q   <= pc_d;
      p_q    <= p_d;
      post_q <= post_d;
      sel_q  <= sel_d;
      byp_q  <= byp_d;
      run_q  <= run_d;
      ph_q   <= ph_d;
    end
  end

  // Half-cycle delayed copy for odd ratios
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ph_n_q <= 1'b0;
    else        ph_n_q <= ph_q;
  end

  always_comb begin
    if (byp_q)      clk_out = clk & run_q;
    else if (odd_q) clk_out = ph_q & ph_n_q;
    else            clk_out = ph_q;
  end

  assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !byp_q) |-> (cnt_q < p_q));

  assert_post_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !byp_q) |-> (pc_q <= f_last_q));

  assert_hold_settings_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !at_last && en) |=> ($stable(p_q) && $stable(post_q) && $stable(sel_q)));

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!run_q && !ph_q));
endmodule

// File: rtl/clk_ratio_chain.sv
`timescale 1ns/1ps
module clk_ratio_chain #(
  parameter int unsigned P_W      = 5,
  parameter int unsigned POST_W   = 2,
  parameter bit          HAS_POST = 1'b1
) (
  input  logic              vco_clk,
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [P_W-1:0]    p_ratio,
  input  logic [POST_W-1:0] post_sel,
  input  logic              src_sel,
  output logic              clk_out
);
  logic [POST_W-1:0] post_eff;
  logic              sel_eff, sel_q, src_clk, rst_core_n;

  generate
    if (HAS_POST) begin : g_post
      assign post_eff = post_sel;
      assign sel_eff  = src_sel;
    end else begin : g_nopost
      assign post_eff = '0;
      assign sel_eff  = 1'b0;
    end
  endgenerate

  rdiv_src_mux u_mux (
    .vco_clk (vco_clk),
    .ref_clk (ref_clk),
    .sel     (sel_q),
    .src_clk (src_clk)
  );

  rdiv_rst_sync u_rst (
    .clk        (src_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rdiv_core #(.P_W(P_W), .POST_W(POST_W)) u_core (
    .clk     (src_clk),
    .rst_n   (rst_core_n),
    .en      (run_en),
    .p_in    (p_ratio),
    .post_in (post_eff),
    .sel_in  (sel_eff),
    .sel_q   (sel_q),
    .clk_out (clk_out)
  );
endmodule

// File: tb/clk_ratio_chain_tb_top.sv
`timescale 1ns/1ps
module clk_ratio_chain_tb_top;
  localparam real T_VCO = 8.0;
  localparam real T_REF = 20.0;

  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [4:0] p_ratio = 5'd4;
  logic [1:0] post_sel = 2'd0;
  logic       src_sel = 1'b0;
  logic       clk_out, clk_out_np;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;
  bit tmo;

  always #(T_VCO/2) vco_clk = ~vco_clk;
  always #(T_REF/2) ref_clk = ~ref_clk;

  clk_ratio_chain dut_i (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .run_en(run_en),
    .p_ratio(p_ratio), .post_sel(post_sel), .src_sel(src_sel), .clk_out(clk_out));

  clk_ratio_chain #(.HAS_POST(1'b0)) dut_np_i (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .run_en(run_en),
    .p_ratio(p_ratio), .post_sel(post_sel), .src_sel(src_sel), .clk_out(clk_out_np));

  function automatic real exp_period(int p, int post, int sel, bit has);
    int n;
    real t;
    n = (p < 2) ? 1 : p * (has ? (1 << post) : 1);
    t = (has && sel == 1) ? T_REF : T_VCO;
    return n * t;
  endfunction

  task automatic check(bit ok, string req, real act, real exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic wait_edge(bit np, bit rise, output realtime t);
    tmo = 1'b0;
    fork
      begin
        if (np) begin
          if (rise) @(posedge clk_out_np); else @(negedge clk_out_np);
        end else begin
          if (rise) @(posedge clk_out); else @(negedge clk_out);
        end
      end
      begin #(20000); tmo = 1'b1; end
    join_any
    disable fork;
    t = $realtime;
    if (tmo) check(1'b0, "timeout", 0.0, 1.0);
  endtask

  // Skip two rising edges, then time the third period
  task automatic measure(bit np, string req, real exp_per);
    realtime t0, t1, t2;
    wait_edge(np, 1'b1, t0);
    wait_edge(np, 1'b1, t0);
    wait_edge(np, 1'b1, t0);
    wait_edge(np, 1'b0, t1);
    wait_edge(np, 1'b1, t2);
    check((t2 - t0) > exp_per - 0.5 && (t2 - t0) < exp_per + 0.5,
          {req, " period"}, t2 - t0, exp_per);
    check((t1 - t0) > exp_per/2 - 0.5 && (t1 - t0) < exp_per/2 + 0.5,
          {req, " high"}, t1 - t0, exp_per/2);
  endtask

  task automatic apply(int p, int post, int sel);
    #1;
    p_ratio  = 5'(p);
    post_sel = 2'(post);
    src_sel  = 1'(sel);
  endtask

  initial begin : watchdog
    #1500000;
    if (!done) begin
      check(1'b0, "watchdog", 0.0, 1.0);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin : stim
    realtime t0, t1, t2;
    int hits;
    void'($urandom(32'd20240611));
    // R9: output low during reset
    hits = 0;
    for (int i = 0; i < 20; i++) begin #3; if (clk_out) hits++; end
    check(hits == 0, "R9 reset low", hits, 0);
    rst_n = 1'b1;
    #50;
    run_en = 1'b1;
    // R1/R2 even ratio on oscillator
    apply(4, 0, 0); measure(0, "R1 R2 p4", exp_period(4, 0, 0, 1));
    // R3 odd ratios
    apply(3, 0, 0); measure(0, "R3 p3", exp_period(3, 0, 0, 1));
    apply(31, 0, 0); measure(0, "R3 p31", exp_period(31, 0, 0, 1));
    // R6 post factors
    apply(5, 1, 0); measure(0, "R6 x2", exp_period(5, 1, 0, 1));
    apply(3, 3, 0); measure(0, "R6 x8", exp_period(3, 3, 0, 1));
    // R5 reference source
    apply(2, 2, 1); measure(0, "R5 ref", exp_period(2, 2, 1, 1));
    // R4 bypass with ratio 0 and 1, post code ignored
    apply(1, 3, 0); measure(0, "R4 p1", exp_period(1, 3, 0, 1));
    apply(0, 2, 1); measure(0, "R4 p0 ref", exp_period(0, 2, 1, 1));
    // R7: change mid-period, old period completes
    apply(7, 0, 0); measure(0, "R7 setup", exp_period(7, 0, 0, 1));
    wait_edge(0, 1'b1, t0);
    #1; p_ratio = 5'd3;
    wait_edge(0, 1'b0, t1);
    wait_edge(0, 1'b1, t2);
    check((t1 - t0) > 27.5 && (t1 - t0) < 28.5, "R7 old high", t1 - t0, 28.0);
    check((t2 - t0) > 55.5 && (t2 - t0) < 56.5, "R7 old period", t2 - t0, 56.0);
    measure(0, "R7 new", exp_period(3, 0, 0, 1));
    // R8: enable low holds output low
    #1; run_en = 1'b0;
    #(3*T_VCO);
    hits = 0;
    for (int i = 0; i < 40; i++) begin #3; if (clk_out) hits++; end
    check(hits == 0, "R8 idle low", hits, 0);
    run_en = 1'b1;
    measure(0, "R8 restart", exp_period(3, 0, 0, 1));
    // R10: variant without post stage ignores post and source
    apply(6, 3, 1); measure(1, "R10 np", exp_period(6, 3, 1, 0));
    // Random trials, R1 R2 R3 R4 R5 R6
    for (int k = 0; k < 14; k++) begin
      int p, po, s;
      p  = $urandom_range(0, 31);
      po = $urandom_range(0, 3);
      s  = $urandom_range(0, 1);
      apply(p, po, s);
      measure(0, "R1 random", exp_period(p, po, s, 1));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule